// File: doc/BRIEF.md
# Register Access Front End with Protection and Alignment Checks

This block is the bus-facing half of a small control and status register file. It sits on an AHB-style bus as a slave. It samples each address phase, decides whether the transfer may reach a register, and drives the data-phase response. For a good write it hands the rest of the design a one-cycle strobe for the addressed register, together with the write data. For a good read it returns that register's value, taken from a flat input bus that carries every register's current contents. The register storage itself lives outside the block.

Two static configuration inputs shape the checks. The first restricts access either to privileged transfers or to user transfers, using protection bit 1. The second turns misaligned addresses into errors; when it is clear, the two low address bits are ignored. A transfer fails if it is any of the following: not a lone word transfer, of the wrong privilege, misaligned while alignment errors are enabled, or aimed outside the register window. Every failed transfer gets the standard two-cycle AHB error response and touches nothing.

Top module: `csr_ahb_front`

## Requirements
- R1: While reset is asserted and in the first cycle after it, hready is 1, hresp is 0 (OKAY), wr_strobe is all zero and hrdata is zero.
- R2: A selected transfer with htrans=SEQ (2'b11), or with htrans=NONSEQ (2'b10) and hsize other than 3'b010 (word), gets an error response and pulses no strobe.
- R3: When priv_only=1 a NONSEQ transfer needs hprot[1]=1, and when priv_only=0 it needs hprot[1]=0. A mismatch gets an error response and pulses no strobe. The other hprot bits have no effect.
- R4: With misalign_err_en=1, a NONSEQ transfer with haddr[1:0] not 00 gets an error response. With misalign_err_en=0 the same transfer proceeds as an access to the word at haddr with bits [1:0] cleared.
- R5: Register i sits at byte offset 4*i for i from 0 to NUM_REGS-1 (12 by default). A NONSEQ transfer whose word index haddr[ADDR_W-1:2] is NUM_REGS or more gets an error response.
- R6: An error response lasts two cycles: the first has hready=0 and hresp=1, and the second has hready=1 and hresp=1. No address phase is taken while hready is 0.
- R7: In the cycle after a valid write's address phase, wr_strobe carries a single 1 at the register index, wr_data equals hwdata, hready=1 and hresp=0. The strobe lasts exactly one cycle.
- R8: In the cycle after a valid read's address phase, hrdata equals reg_rd_bus[32*i +: 32] for register index i, hready=1 and hresp=0. In every other cycle hrdata is zero.
- R9: An address phase with hsel=0, or with htrans of IDLE (2'b00) or BUSY (2'b01), is followed by a cycle with hready=1, hresp=0 and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select for the current address phase |
| haddr | input | ADDR_W (8) | Byte address |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size; only 3'b010 is legal |
| hprot | input | 4 | Protection attributes; bit 1 marks privileged |
| hwdata | input | 32 | Write data, valid in the data phase |
| priv_only | input | 1 | 1: privileged-only access, 0: user-only access |
| misalign_err_en | input | 1 | 1: misaligned addresses get an error response |
| reg_rd_bus | input | NUM_REGS*32 | Current contents of all registers, register i in bits [32*i +: 32] |
| hrdata | output | 32 | Read data |
| hready | output | 1 | Transfer done; also gates the next address phase |
| hresp | output | 1 | 0 OKAY, 1 ERROR |
| wr_strobe | output | NUM_REGS | One-cycle write enable per register |
| wr_data | output | 32 | Data to store when a strobe is high |

## Verification
The bench targets the edge of the register window: the last mapped word must give OKAY and the first unmapped word must give ERROR. A decoder that is off by one would either strobe a register that does not exist or reject the top register. It also drives misaligned addresses with the enable both set and clear. A design that ignored the enable would either accept bad addresses or reject ones that should be aligned down to a word. It checks both polarities of the privilege setting, because a design that inverted the sense would fail every good access. It also checks both cycles of the error response and the cycle after it, where a broken sequence shows up as a missing wait cycle, a stuck hready, or a write strobe firing on a rejected transfer.

// File: rtl/csr_front_pkg.sv
package csr_front_pkg;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [2:0] SZ_WORD   = 3'b010;

    localparam logic RESP_OKAY  = 1'b0;
    localparam logic RESP_ERROR = 1'b1;

    // Data-phase state of the slave
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WRITE,
        PH_READ,
        PH_ERR_WAIT,
        PH_ERR_DONE
    } phase_e;

    // Outcome of the address-phase checks
    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_WRITE,
        ACC_READ,
        ACC_FAULT
    } verdict_e;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode #(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 12,
    parameter int IDX_W    = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              misaligned_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;

    assign word_idx     = addr_i[ADDR_W-1:2];
    assign misaligned_o = |addr_i[1:0];
    assign hit_o        = {1'b0, word_idx} < (WORD_W + 1)'(NUM_REGS);
    assign idx_o        = word_idx[IDX_W-1:0];

endmodule

// File: rtl/csr_access_check.sv
module csr_access_check
    import csr_front_pkg::*;
(
    input  logic       sel_i,
    input  logic [1:0] trans_i,
    input  logic       write_i,
    input  logic [2:0] size_i,
    input  logic       prot_priv_i,
    input  logic       priv_only_i,
    input  logic       misalign_en_i,
    input  logic       hit_i,
    input  logic       misaligned_i,
    output verdict_e   verdict_o
);
    logic active;
    logic bad_kind;
    logic bad_prot;
    logic bad_align;

    assign active    = sel_i && trans_i[1];
    assign bad_kind  = (trans_i == TR_SEQ) || (size_i != SZ_WORD);
    assign bad_prot  = prot_priv_i != priv_only_i;
    assign bad_align = misalign_en_i && misaligned_i;

    always_comb begin
        if (!active) begin
            verdict_o = ACC_NONE;
        end else if (bad_kind || bad_prot || bad_align || !hit_i) begin
            verdict_o = ACC_FAULT;
        end else if (write_i) begin
            verdict_o = ACC_WRITE;
        end else begin
            verdict_o = ACC_READ;
        end
    end

endmodule

// File: rtl/csr_resp_fsm.sv
module csr_resp_fsm
    import csr_front_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  verdict_e         verdict_i,
    input  logic [IDX_W-1:0] idx_i,
    output phase_e           phase_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             hready_o,
    output logic             hresp_o
);
    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] idx;
    } fsm_t;

    fsm_t st_d;
    fsm_t st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == PH_ERR_WAIT) begin
            st_d.phase = PH_ERR_DONE;
        end else begin
            st_d.idx = idx_i;
            case (verdict_i)
                ACC_WRITE: st_d.phase = PH_WRITE;
                ACC_READ:  st_d.phase = PH_READ;
                ACC_FAULT: st_d.phase = PH_ERR_WAIT;
                default:   st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o  = st_q.phase;
    assign idx_o    = st_q.idx;
    assign hready_o = st_q.phase != PH_ERR_WAIT;
    assign hresp_o  = (st_q.phase == PH_ERR_WAIT) || (st_q.phase == PH_ERR_DONE);

    // R6
    err_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready_o) |=> (hready_o && hresp_o));

    // R6
    err_wait_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready_o) |=> $stable(st_q.idx));

endmodule

// File: rtl/csr_strobe_gen.sv
module csr_strobe_gen #(
    parameter int NUM_REGS = 12,
    parameter int IDX_W    = 4
) (
    input  logic                en_i,
    input  logic [IDX_W-1:0]    idx_i,
    output logic [NUM_REGS-1:0] strobe_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_strobe
        assign strobe_o[g] = en_i && (idx_i == IDX_W'(g));
    end

endmodule

// File: rtl/csr_rdata_mux.sv
module csr_rdata_mux #(
    parameter int NUM_REGS = 12,
    parameter int IDX_W    = 4,
    parameter int DATA_W   = 32
) (
    input  logic                       en_i,
    input  logic [IDX_W-1:0]           idx_i,
    input  logic [NUM_REGS*DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0]          data_o
);
    logic [DATA_W-1:0] words [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        assign words[g] = bus_i[g*DATA_W +: DATA_W];
    end

    always_comb begin
        data_o = '0;
        if (en_i && ({1'b0, idx_i} < (IDX_W + 1)'(NUM_REGS))) begin
            data_o = words[idx_i];
        end
    end

endmodule

// File: rtl/csr_ahb_front.sv
module csr_ahb_front
    import csr_front_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 12,
    parameter int DATA_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hsel,
    input  logic [ADDR_W-1:0]          haddr,
    input  logic [1:0]                 htrans,
    input  logic                       hwrite,
    input  logic [2:0]                 hsize,
    input  logic [3:0]                 hprot,
    input  logic [DATA_W-1:0]          hwdata,
    input  logic                       priv_only,
    input  logic                       misalign_err_en,
    input  logic [NUM_REGS*DATA_W-1:0] reg_rd_bus,
    output logic [DATA_W-1:0]          hrdata,
    output logic                       hready,
    output logic                       hresp,
    output logic [NUM_REGS-1:0]        wr_strobe,
    output logic [DATA_W-1:0]          wr_data
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic             dec_hit;
    logic             dec_misaligned;
    logic [IDX_W-1:0] dec_idx;
    verdict_e         verdict;
    phase_e           phase;
    logic [IDX_W-1:0] phase_idx;
    logic             unused_prot_bits;

    assign unused_prot_bits = ^{hprot[3:2], hprot[0]};

    csr_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr_i       (haddr),
        .hit_o        (dec_hit),
        .idx_o        (dec_idx),
        .misaligned_o (dec_misaligned)
    );

    csr_access_check u_check (
        .sel_i         (hsel),
        .trans_i       (htrans),
        .write_i       (hwrite),
        .size_i        (hsize),
        .prot_priv_i   (hprot[1]),
        .priv_only_i   (priv_only),
        .misalign_en_i (misalign_err_en),
        .hit_i         (dec_hit),
        .misaligned_i  (dec_misaligned),
        .verdict_o     (verdict)
    );

    csr_resp_fsm #(
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .verdict_i (verdict),
        .idx_i     (dec_idx),
        .phase_o   (phase),
        .idx_o     (phase_idx),
        .hready_o  (hready),
        .hresp_o   (hresp)
    );

    csr_strobe_gen #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_strobe (
        .en_i     (phase == PH_WRITE),
        .idx_i    (phase_idx),
        .strobe_o (wr_strobe)
    );

    csr_rdata_mux #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .DATA_W   (DATA_W)
    ) u_rmux (
        .en_i   (phase == PH_READ),
        .idx_i  (phase_idx),
        .bus_i  (reg_rd_bus),
        .data_o (hrdata)
    );

    assign wr_data = hwdata;

    // R3
    priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && hsel && htrans == TR_NONSEQ && hprot[1] != priv_only)
        |=> (!hready && hresp && wr_strobe == '0));

    // R5
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && hsel && htrans == TR_NONSEQ
         && {1'b0, haddr[ADDR_W-1:2]} >= (ADDR_W - 1)'(NUM_REGS))
        |=> (!hready && hresp));

    // R7
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_strobe));

    // R7
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_strobe) |-> $past(hready && hsel && htrans == TR_NONSEQ && hwrite));

    // R9
    idle_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && !(hsel && htrans[1]))
        |=> (hready && !hresp && wr_strobe == '0));

endmodule

// File: tb/csr_ahb_front_tb.sv
`timescale 1ns/1ps
module csr_ahb_front_tb_top;
    localparam int ADDR_W   = 8;
    localparam int NUM_REGS = 12;
    localparam int DATA_W   = 32;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       hsel = 1'b0;
    logic [ADDR_W-1:0]          haddr = '0;
    logic [1:0]                 htrans = 2'b00;
    logic                       hwrite = 1'b0;
    logic [2:0]                 hsize = 3'b010;
    logic [3:0]                 hprot = 4'b0011;
    logic [DATA_W-1:0]          hwdata = '0;
    logic                       priv_only = 1'b1;
    logic                       misalign_err_en = 1'b1;
    logic [NUM_REGS*DATA_W-1:0] reg_rd_bus;
    logic [DATA_W-1:0]          hrdata;
    logic                       hready;
    logic                       hresp;
    logic [NUM_REGS-1:0]        wr_strobe;
    logic [DATA_W-1:0]          wr_data;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    csr_ahb_front #(
        .ADDR_W (ADDR_W), .NUM_REGS (NUM_REGS), .DATA_W (DATA_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .hsel (hsel), .haddr (haddr),
        .htrans (htrans), .hwrite (hwrite), .hsize (hsize), .hprot (hprot),
        .hwdata (hwdata), .priv_only (priv_only),
        .misalign_err_en (misalign_err_en), .reg_rd_bus (reg_rd_bus),
        .hrdata (hrdata), .hready (hready), .hresp (hresp),
        .wr_strobe (wr_strobe), .wr_data (wr_data)
    );

    function automatic logic [31:0] reg_word(int i);
        return 32'h5A00_00F0 ^ (i * 32'h0103_0507);
    endfunction

    // 0 none, 1 write, 2 read, 3 error
    function automatic int kind_of(bit sel, logic [1:0] tr, bit wr, logic [2:0] sz,
                                   logic [3:0] prot, logic [7:0] addr, bit priv, bit mis);
        if (!sel || !tr[1]) return 0;
        if (tr == 2'b11 || sz != 3'b010) return 3;
        if (prot[1] != priv) return 3;
        if (mis && addr[1:0] != 2'b00) return 3;
        if (int'(addr[7:2]) >= NUM_REGS) return 3;
        return wr ? 1 : 2;
    endfunction

    function automatic string tag_of(bit sel, logic [1:0] tr, bit wr, logic [2:0] sz,
                                     logic [3:0] prot, logic [7:0] addr, bit priv, bit mis);
        if (!sel || !tr[1]) return "R9";
        if (tr == 2'b11 || sz != 3'b010) return "R2";
        if (prot[1] != priv) return "R3";
        if (mis && addr[1:0] != 2'b00) return "R4";
        if (int'(addr[7:2]) >= NUM_REGS) return "R5";
        return wr ? "R7" : "R8";
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic xfer(bit sel, logic [1:0] tr, bit wr, logic [2:0] sz, logic [3:0] prot,
                        logic [7:0] addr, logic [31:0] wd, bit priv, bit mis);
        int k;
        int idx;
        string tg;
        k   = kind_of(sel, tr, wr, sz, prot, addr, priv, mis);
        tg  = tag_of(sel, tr, wr, sz, prot, addr, priv, mis);
        idx = int'(addr[7:2]);
        @(negedge clk);
        hsel = sel; htrans = tr; hwrite = wr; hsize = sz; hprot = prot;
        haddr = addr; priv_only = priv; misalign_err_en = mis;
        @(posedge clk);
        #1;
        hsel = 1'b0; htrans = 2'b00; hwdata = wd;
        #1;
        case (k)
            1: begin
                chk(tg, "write strobe", 32'(wr_strobe), 32'(1) << idx);
                chk(tg, "write data", wr_data, wd);
                chk(tg, "write hready", 32'(hready), 32'd1);
                chk(tg, "write hresp", 32'(hresp), 32'd0);
                @(posedge clk); #1;
                chk("R7", "strobe after one cycle", 32'(wr_strobe), 32'd0);
            end
            2: begin
                chk(tg, "read data", hrdata, reg_word(idx));
                chk(tg, "read hready", 32'(hready), 32'd1);
                chk(tg, "read hresp", 32'(hresp), 32'd0);
                chk(tg, "read strobe", 32'(wr_strobe), 32'd0);
            end
            3: begin
                chk(tg, "err cycle1 hready", 32'(hready), 32'd0);
                chk("R6", "err cycle1 hresp", 32'(hresp), 32'd1);
                chk(tg, "err strobe", 32'(wr_strobe), 32'd0);
                @(posedge clk); #1;
                chk("R6", "err cycle2 hready", 32'(hready), 32'd1);
                chk("R6", "err cycle2 hresp", 32'(hresp), 32'd1);
                chk(tg, "err cycle2 strobe", 32'(wr_strobe), 32'd0);
                @(posedge clk); #1;
                chk("R6", "after err hresp", 32'(hresp), 32'd0);
            end
            default: begin
                chk(tg, "idle hready", 32'(hready), 32'd1);
                chk(tg, "idle hresp", 32'(hresp), 32'd0);
                chk(tg, "idle strobe", 32'(wr_strobe), 32'd0);
                chk("R8", "idle hrdata", hrdata, 32'd0);
            end
        endcase
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < NUM_REGS; i++) reg_rd_bus[i*DATA_W +: DATA_W] = reg_word(i);
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd2718));
        #1;
        chk("R1", "reset hready", 32'(hready), 32'd1);
        chk("R1", "reset hresp", 32'(hresp), 32'd0);
        chk("R1", "reset strobe", 32'(wr_strobe), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "post-reset hready", 32'(hready), 32'd1);
        chk("R1", "post-reset hrdata", hrdata, 32'd0);

        // R7 lowest and highest register
        xfer(1, 2'b10, 1, 3'b010, 4'b0011, 8'h00, 32'hDEAD_0001, 1, 1);
        xfer(1, 2'b10, 1, 3'b010, 4'b0011, 8'h2C, 32'hBEEF_0B0B, 1, 1);
        // R8
        xfer(1, 2'b10, 0, 3'b010, 4'b0010, 8'h14, 32'h0, 1, 1);
        // R3 both polarities
        xfer(1, 2'b10, 0, 3'b010, 4'b0001, 8'h14, 32'h0, 1, 1);
        xfer(1, 2'b10, 0, 3'b010, 4'b1101, 8'h08, 32'h0, 0, 1);
        xfer(1, 2'b10, 1, 3'b010, 4'b0010, 8'h08, 32'h1234_5678, 0, 1);
        // R4 misaligned with and without error enable
        xfer(1, 2'b10, 0, 3'b010, 4'b0010, 8'h15, 32'h0, 1, 1);
        xfer(1, 2'b10, 0, 3'b010, 4'b0010, 8'h17, 32'h0, 1, 0);
        xfer(1, 2'b10, 1, 3'b010, 4'b0010, 8'h0A, 32'hCAFE_0202, 1, 0);
        // R5 window edge
        xfer(1, 2'b10, 0, 3'b010, 4'b0010, 8'h30, 32'h0, 1, 1);
        xfer(1, 2'b10, 1, 3'b010, 4'b0010, 8'hFC, 32'h0, 1, 1);
        // R2 size and burst
        xfer(1, 2'b10, 1, 3'b000, 4'b0010, 8'h04, 32'h0, 1, 1);
        xfer(1, 2'b11, 0, 3'b010, 4'b0010, 8'h04, 32'h0, 1, 1);
        // R9 IDLE, BUSY, deselected
        xfer(1, 2'b00, 1, 3'b010, 4'b0010, 8'h04, 32'h0, 1, 1);
        xfer(1, 2'b01, 1, 3'b010, 4'b0010, 8'h04, 32'h0, 1, 1);
        xfer(0, 2'b10, 1, 3'b010, 4'b0010, 8'h04, 32'h0, 1, 1);

        for (int n = 0; n < 600; n++) begin
            logic [1:0] tr;
            logic [2:0] sz;
            logic [7:0] ad;
            tr = ($urandom % 3 != 0) ? 2'b10 : 2'($urandom);
            sz = ($urandom % 5 == 0) ? 3'($urandom) : 3'b010;
            ad = ($urandom % 2 == 0) ? 8'(($urandom % NUM_REGS) * 4) : 8'($urandom);
            xfer(1'($urandom % 8 != 0), tr, 1'($urandom), sz, 4'($urandom), ad,
                 $urandom, 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        summary();
    end

endmodule